// File: doc/BRIEF.md
# Reset Strap Drive Sequencer

This block sits between a chip's reset logic and a shared parallel bus. It owns the bus reset wire and a small set of configuration strap pins. The strap pins are used as ordinary bus signals in normal operation. While bus reset is active the block drives known values onto these pins, so that the attached agent can latch them on the edge where reset goes inactive. The pins are active-low: a strap that is logically asserted pulls the wire low. There are two kinds of pin. The bus-request straps are always asserted. The address straps take their value from a strap input.

Reset release is not simply a copy of the request input. The block counts how many clocks the driven strap levels have stayed unchanged, and it lets reset go inactive only once that count reaches the setup minimum. Any change to an address strap during reset restarts the count. After release the straps stay driven for a hold window taken from a configuration input, limited to between 2 and 20 clocks. The block then turns off every output enable so the pins can return to bus use.

An override input can force reset to release at once. If that happens before the setup minimum has been reached, the block sets a sticky error flag.

Top module: `rss_strap_seq`

## Requirements
- R1: While `rst_n` is low the bus reset output is asserted (`bus_rst_n_o`=0), every pin enable is 1, the request pins (bits 0 and 1) are at wire level 0, the address strap pin (bit 2) is at wire level 1 (logical 0), and `setup_err_o` is 0.
- R2: Whenever bus reset is asserted, both request pins (bits 0 and 1) are enabled and held at wire level 0.
- R3: The address strap pin (bit 2) carries the inverse of `addr_strap_i` while reset is asserted. From the release edge until the hold window ends, its level is frozen and ignores `addr_strap_i`.
- R4: Reset is released no earlier than 4 clocks after the last change of the driven strap levels. With no request and no change, release comes exactly 4 clocks after the last change. A strap change during reset restarts this count.
- R5: While `rst_req_i` is 1, bus reset stays asserted, unless `force_release_i` overrides it.
- R6: After release the pin enables stay at all ones for H clocks, where H is `hold_cfg_i` clamped to the range 2..20. After that the enables are all zero and every pin level reads 1.
- R7: `force_release_i` during reset releases bus reset on the next edge. If fewer than 4 stable clocks have passed at that point, `setup_err_o` is set and stays set until `rst_n` is asserted.
- R8: When the block is idle (reset released and hold window over), `rst_req_i` asserts bus reset on the next clock edge.
- R9: A request that arrives during the hold window does not shorten or interrupt it. Reset is reasserted only after the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Block reset, active low |
| rst_req_i | input | 1 | Request to hold the bus in reset |
| force_release_i | input | 1 | External override that releases bus reset at once |
| addr_strap_i | input | N_ADDR | Logical values for the address strap pins |
| hold_cfg_i | input | CFG_W | Requested hold window length in clocks, before clamping |
| bus_rst_n_o | output | 1 | Bus reset wire, active low |
| pin_oe_o | output | N_REQ+N_ADDR | Per-pin output enables; request pins are the low bits |
| pin_lvl_o | output | N_REQ+N_ADDR | Per-pin wire levels (active-low encoding) |
| setup_err_o | output | 1 | Sticky flag: reset was forced out before setup completed |

## Verification
If the setup counter misses a restart or saturates at the wrong value, the bus reset wire rises one or more clocks off the expected edge. The bench catches this with a cycle-exact count of reset-low samples. A hold counter that loads the wrong clamp or drops out early shows up as an enable window of the wrong length. The bench catches this by counting enable samples after every release, and a stuck state register would leave the enables on past the window. A sticky-flag fault or a missed override appears on the error pin or the reset wire one clock after the forcing edge.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_HOLD  = 2'd2
  } rss_state_e;
endpackage

// File: rtl/rss_setup_timer.sv
// Tracks the address strap values driven during reset and counts stable clocks.
module rss_setup_timer #(
  parameter int N_ADDR    = 1,
  parameter int SETUP_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              track_i,
  input  logic [N_ADDR-1:0] strap_i,
  output logic [N_ADDR-1:0] drv_o,
  output logic              done_o
);
  localparam int CW = $clog2(SETUP_MIN + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_MIN - 1);

  logic [N_ADDR-1:0] drv_q;
  logic [CW-1:0]     cnt_q;
  logic              changed;

  assign changed = (strap_i != drv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      drv_q <= strap_i;
      cnt_q <= '0;
    end else if (track_i) begin
      if (changed) begin
        drv_q <= strap_i;
        cnt_q <= '0;
      end else if (cnt_q < SETUP_LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign drv_o  = drv_q;
  assign done_o = track_i && !changed && (cnt_q >= SETUP_LAST);
endmodule

// File: rtl/rss_hold_timer.sv
// Clamps the requested hold length and counts the post-release drive window.
module rss_hold_timer #(
  parameter int CFG_W    = 5,
  parameter int HOLD_MIN = 2,
  parameter int HOLD_MAX = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             last_o
);
  localparam int CW = $clog2(HOLD_MAX + 1);

  logic [CW-1:0] clamped;
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (int'(cfg_i) < HOLD_MIN)      clamped = CW'(HOLD_MIN);
    else if (int'(cfg_i) > HOLD_MAX) clamped = CW'(HOLD_MAX);
    else                             clamped = CW'(cfg_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= clamped;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = run_i && (cnt_q == CW'(1));
endmodule

// File: rtl/rss_pin_drive.sv
// Maps logical strap values to active-low wire levels and enables per pin.
module rss_pin_drive #(
  parameter int N_REQ  = 2,
  parameter int N_ADDR = 1
) (
  input  logic                    drive_en_i,
  input  logic [N_ADDR-1:0]       addr_val_i,
  output logic [N_REQ+N_ADDR-1:0] oe_o,
  output logic [N_REQ+N_ADDR-1:0] lvl_o
);
  for (genvar j = 0; j < N_REQ; j++) begin : g_req
    assign oe_o[j]  = drive_en_i;
    assign lvl_o[j] = !drive_en_i;
  end

  for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
    assign oe_o[N_REQ+i]  = drive_en_i;
    assign lvl_o[N_REQ+i] = drive_en_i ? !addr_val_i[i] : 1'b1;
  end
endmodule

// File: rtl/rss_strap_seq.sv
module rss_strap_seq
  import rss_pkg::*;
#(
  parameter int N_REQ     = 2,
  parameter int N_ADDR    = 1,
  parameter int CFG_W     = 5,
  parameter int SETUP_MIN = 4,
  parameter int HOLD_MIN  = 2,
  parameter int HOLD_MAX  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rst_req_i,
  input  logic                    force_release_i,
  input  logic [N_ADDR-1:0]       addr_strap_i,
  input  logic [CFG_W-1:0]        hold_cfg_i,
  output logic                    bus_rst_n_o,
  output logic [N_REQ+N_ADDR-1:0] pin_oe_o,
  output logic [N_REQ+N_ADDR-1:0] pin_lvl_o,
  output logic                    setup_err_o
);
  rss_state_e        state_q, state_d;
  logic              err_q, err_d;
  logic              setup_done, hold_last;
  logic              restart, load_hold;
  logic [N_ADDR-1:0] addr_drv;

  always_comb begin
    state_d   = state_q;
    err_d     = err_q;
    restart   = 1'b0;
    load_hold = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rst_req_i) begin
          state_d = ST_RESET;
          restart = 1'b1;
        end
      end
      ST_RESET: begin
        if (force_release_i) begin
          state_d   = ST_HOLD;
          load_hold = 1'b1;
          if (!setup_done) err_d = 1'b1;
        end else if (!rst_req_i && setup_done) begin
          state_d   = ST_HOLD;
          load_hold = 1'b1;
        end
      end
      ST_HOLD: begin
        if (hold_last) state_d = ST_IDLE;
      end
      default: state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  rss_setup_timer #(.N_ADDR(N_ADDR), .SETUP_MIN(SETUP_MIN)) setup_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .track_i   (state_q == ST_RESET),
    .strap_i   (addr_strap_i),
    .drv_o     (addr_drv),
    .done_o    (setup_done)
  );

  rss_hold_timer #(.CFG_W(CFG_W), .HOLD_MIN(HOLD_MIN), .HOLD_MAX(HOLD_MAX)) hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_hold),
    .run_i  (state_q == ST_HOLD),
    .cfg_i  (hold_cfg_i),
    .last_o (hold_last)
  );

  rss_pin_drive #(.N_REQ(N_REQ), .N_ADDR(N_ADDR)) pins_i (
    .drive_en_i (state_q != ST_IDLE),
    .addr_val_i (addr_drv),
    .oe_o       (pin_oe_o),
    .lvl_o      (pin_lvl_o)
  );

  assign bus_rst_n_o = (state_q != ST_RESET);
  assign setup_err_o = err_q;
endmodule

// File: rtl/rss_strap_seq_chk.sv
module rss_strap_seq_chk #(
  parameter int N_REQ     = 2,
  parameter int N_ADDR    = 1,
  parameter int SETUP_MIN = 4,
  parameter int HOLD_MAX  = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    force_release_i,
  input logic                    bus_rst_n_o,
  input logic [N_REQ+N_ADDR-1:0] pin_oe_o,
  input logic [N_REQ+N_ADDR-1:0] pin_lvl_o,
  input logic                    setup_err_o
);
  localparam int NP = N_REQ + N_ADDR;

  logic [NP-1:0] prev_lvl;
  logic [7:0]    stab_cnt;
  logic [7:0]    hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      stab_cnt <= '0;
      hold_cnt <= '0;
    end else begin
      prev_lvl <= pin_lvl_o;
      if (pin_lvl_o != prev_lvl) stab_cnt <= 8'd1;
      else if (stab_cnt != 8'hFF) stab_cnt <= stab_cnt + 8'd1;
      if (!bus_rst_n_o) hold_cnt <= '0;
      else if (pin_oe_o != '0 && hold_cnt != 8'hFF) hold_cnt <= hold_cnt + 8'd1;
    end
  end

  AST_REQ_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n_o |-> (pin_lvl_o[N_REQ-1:0] == '0) && (&pin_oe_o[N_REQ-1:0])); // R2
  AST_SETUP_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_n_o) && !$past(force_release_i) |-> stab_cnt >= 8'(SETUP_MIN)); // R4
  AST_HOLD_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_n_o) |=> (&pin_oe_o)); // R6
  AST_HOLD_MAX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= 8'(HOLD_MAX)); // R6
  AST_RELEASED_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o == '0) |-> (&pin_lvl_o)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    setup_err_o |=> setup_err_o); // R7
  AST_ERR_ONLY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_err_o) |-> $past(force_release_i)); // R7
  AST_HOLD_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_n_o && (pin_oe_o != '0) |=> bus_rst_n_o); // R9
endmodule

bind rss_strap_seq rss_strap_seq_chk #(
  .N_REQ(N_REQ), .N_ADDR(N_ADDR), .SETUP_MIN(SETUP_MIN), .HOLD_MAX(HOLD_MAX)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .force_release_i (force_release_i),
  .bus_rst_n_o     (bus_rst_n_o),
  .pin_oe_o        (pin_oe_o),
  .pin_lvl_o       (pin_lvl_o),
  .setup_err_o     (setup_err_o)
);

// File: tb/rss_strap_seq_tb.sv
module rss_strap_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rst_req;
  logic       force_rel;
  logic [0:0] strap;
  logic [4:0] hold_cfg;
  logic       bus_rst_n;
  logic [2:0] oe;
  logic [2:0] lvl;
  logic       serr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rss_strap_seq dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .rst_req_i       (rst_req),
    .force_release_i (force_rel),
    .addr_strap_i    (strap),
    .hold_cfg_i      (hold_cfg),
    .bus_rst_n_o     (bus_rst_n),
    .pin_oe_o        (oe),
    .pin_lvl_o       (lvl),
    .setup_err_o     (serr)
  );

  // {strap, hold_cfg, expected hold length}
  localparam logic [10:0] VEC [0:6] = '{
    {1'b0, 5'd0,  5'd2},
    {1'b1, 5'd1,  5'd2},
    {1'b0, 5'd2,  5'd2},
    {1'b1, 5'd7,  5'd7},
    {1'b0, 5'd20, 5'd20},
    {1'b1, 5'd21, 5'd20},
    {1'b0, 5'd31, 5'd20}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts at a sample point; counts reset-low samples, then enabled-hold samples.
  task automatic measure(output int lows, output int holds);
    lows = 0;
    holds = 0;
    while (!bus_rst_n && lows < 100) begin lows++; @(negedge clk); end
    while (bus_rst_n && oe != 3'b000 && holds < 100) begin holds++; @(negedge clk); end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lows, holds;
    rst_n = 1'b0; rst_req = 1'b1; force_rel = 1'b0; strap = 1'b0; hold_cfg = 5'd5;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bus_rst_n == 1'b0, "R1 rst", bus_rst_n, 0);
    check(oe == 3'b111, "R1 oe", oe, 7);
    check(lvl == 3'b100, "R1 lvl", lvl, 4);
    check(serr == 1'b0, "R1 err", serr, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(bus_rst_n == 1'b0, "R5 held by request", bus_rst_n, 0);
    // R4: strap change restarts setup count
    strap = 1'b1; rst_req = 1'b0;
    @(negedge clk);
    check(lvl == 3'b000, "R3 new strap level", lvl, 0);
    measure(lows, holds);
    check(lows == 4, "R4 restart count", lows, 4);
    check(holds == 5, "R6 hold 5", holds, 5);
    check(lvl == 3'b111, "R6 released level", lvl, 7);

    // Vector walk: clamping and strap levels
    foreach (VEC[v]) begin
      strap = VEC[v][10]; hold_cfg = VEC[v][9:5]; rst_req = 1'b1;
      @(negedge clk);
      check(bus_rst_n == 1'b0, "R8 entry", bus_rst_n, 0);
      check(lvl == {~VEC[v][10], 2'b00}, "R2 R3 levels", lvl, {~VEC[v][10], 2'b00});
      rst_req = 1'b0;
      measure(lows, holds);
      check(lows == 4, "R4 setup", lows, 4);
      check(holds == int'(VEC[v][4:0]), "R6 clamp", holds, VEC[v][4:0]);
      check(oe == 3'b000 && lvl == 3'b111, "R6 tristate", {oe, lvl}, 6'b000111);
    end

    // R3 freeze during hold
    strap = 1'b0; hold_cfg = 5'd4; rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    while (!bus_rst_n) @(negedge clk);
    strap = 1'b1;
    @(negedge clk);
    check(oe == 3'b111 && lvl[2] == 1'b1, "R3 frozen", {oe, lvl}, 6'b111100);
    while (oe != 3'b000) @(negedge clk);

    // R7 forced early release
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0; force_rel = 1'b1;
    @(negedge clk);
    force_rel = 1'b0;
    check(bus_rst_n == 1'b1, "R7 forced release", bus_rst_n, 1);
    check(serr == 1'b1, "R7 error set", serr, 1);
    while (oe != 3'b000) @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    measure(lows, holds);
    check(serr == 1'b1, "R7 sticky", serr, 1);
    rst_n = 1'b0; rst_req = 1'b1;
    @(negedge clk);
    check(serr == 1'b0, "R1 R7 cleared", serr, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    force_rel = 1'b1;
    @(negedge clk);
    force_rel = 1'b0; rst_req = 1'b0;
    check(bus_rst_n == 1'b1 && serr == 1'b0, "R7 late force ok", {bus_rst_n, serr}, 2);
    while (oe != 3'b000) @(negedge clk);

    // R9 request during hold, then R8 reentry
    hold_cfg = 5'd20; rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    while (!bus_rst_n) @(negedge clk);
    rst_req = 1'b1;
    measure(lows, holds);
    check(holds == 20, "R9 hold not cut", holds, 20);
    @(negedge clk);
    check(bus_rst_n == 1'b0, "R8 reentry", bus_rst_n, 0);
    rst_req = 1'b0;
    measure(lows, holds);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule